// File: doc/BRIEF.md
# Key-Locked Watchdog Timer with Early Warning

This block is a watchdog timer reached over a simple register bus with 32-bit words and 16 live data bits per register. It counts down on a slow tick enable, nominally 32768 ticks per second, that arrives next to the bus clock. Software stores a timeout and an early-warning threshold. Each is a 32-bit tick count split into two 16-bit halves. The new values take effect only after a short settling period, and a busy flag is visible during that period.

All register writes are refused unless the block has first been opened with a 16-bit key. When the running count lands on the early-warning threshold, a status flag is set and a maskable interrupt can follow. When the count runs out, the count reloads from the timeout. If reset is enabled, the block also latches a reset flag and sends a single-cycle reset request to the system. Rewriting the load registers while the count runs serves as the keep-alive: the count restarts from the stored timeout once the settling period ends.

The bus has no handshake. A write is taken on any clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The block never stalls the bus, so it has no back-pressure.

Top module: `keylock_watchdog`

## Requirements
- R1: After reset the block is locked. Writing 0xE551 to offset 0x20 unlocks it, and writing any other value to 0x20 locks it. Reading 0x20 returns 1 in bit 0 while unlocked and 0 while locked.
- R2: While locked, a write to any offset other than 0x20 changes no register. For example, the control register keeps its value, and a write to a load register does not set the busy bit.
- R3: The timeout is written as a low half at 0x00 and a high half at 0x04. The early-warning threshold is written as a low half at 0x2C and a high half at 0x30. Each half holds 16 bits and reads back at its own offset.
- R4: A write to any of the four load offsets sets busy, which is bit 4 of raw status at 0x10. Busy clears on the LOAD_TICKS-th tick after the last such write (default 2). On that same edge, the count takes the stored timeout and the compare takes the stored threshold.
- R5: The count reads as a low half at 0x18 and a high half at 0x1C. It decreases by one on each tick while control bit 1 is set. It does not change when there is no tick or when bit 1 is clear.
- R6: When a tick decrements the count to a value equal to the threshold, raw status bit 0 is set. `wdt_irq` is high exactly when raw bit 0 is set, control bit 0 is 1, and bit 0 of the mask register at 0x14 is 0.
- R7: A tick that finds the count at 1 or 0 reloads the stored timeout. If control bit 3 is set, that tick also sets raw bit 3 and raises `wdt_rst_req` for exactly one clock cycle. If bit 3 is clear, nothing else happens.
- R8: Writing 1 to bit 0 or bit 3 at offset 0x0C clears the matching raw status bit. Writing 0 to a bit leaves that bit unchanged.
- R9: Rewriting a load register while the count runs restarts the count from the new timeout when busy clears. Until then the count keeps counting down from its old value.
- R10: The control register at 0x08 stores bits 3:0 and reads them back. Bit 0 enables the interrupt, bit 1 enables counting, bit 2 selects the new mode and is only stored, and bit 3 enables reset. After reset, control, mask, status, count and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Slow tick enable, one clock cycle wide |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data; bits 15:0 are used |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| wdt_irq | output | 1 | Early-warning interrupt (level) |
| wdt_rst_req | output | 1 | Reset request, a single-cycle pulse |

## Verification
The assertions assume that `tick_en` is never high on two clock edges in a row, which is how a slow tick is brought into a fast clock domain. Under that assumption, a reset pulse is always followed by a cycle without one. The bench therefore raises the tick for one cycle at a time and always leaves at least one idle cycle after it. The bench changes bus inputs only on falling edges, so every write is seen by exactly one rising edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Byte offsets of the register window.
  localparam int unsigned OFF_TO_LO  = 'h00;
  localparam int unsigned OFF_TO_HI  = 'h04;
  localparam int unsigned OFF_CTRL   = 'h08;
  localparam int unsigned OFF_CLR    = 'h0C;
  localparam int unsigned OFF_RAW    = 'h10;
  localparam int unsigned OFF_MASK   = 'h14;
  localparam int unsigned OFF_CNT_LO = 'h18;
  localparam int unsigned OFF_CNT_HI = 'h1C;
  localparam int unsigned OFF_LOCK   = 'h20;
  localparam int unsigned OFF_PRE_LO = 'h2C;
  localparam int unsigned OFF_PRE_HI = 'h30;

  localparam logic [15:0] OPEN_KEY = 16'hE551;

  // Status bit positions.
  localparam int unsigned RAW_PRE_BIT  = 0;
  localparam int unsigned RAW_RST_BIT  = 3;
  localparam int unsigned RAW_BUSY_BIT = 4;

  // Control word, laid out from bit 3 down to bit 0.
  typedef struct packed {
    logic rst_en;
    logic new_mode;
    logic cnt_en;
    logic int_en;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int ADDR_W = 6,
  parameter int BUS_W  = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              pre_hit_i,
  input  logic              expire_i,
  output logic              unlocked_o,
  output wdt_ctrl_t         ctrl_o,
  output logic              mask_o,
  output logic [CNT_W-1:0]  to_val_o,
  output logic [CNT_W-1:0]  pre_val_o,
  output logic              raw_pre_o,
  output logic              raw_rst_o,
  output logic              load_wr_o
);
  logic              unlocked_q;
  wdt_ctrl_t         ctrl_q;
  logic              mask_q;
  logic [HALF_W-1:0] to_hi_q, to_lo_q, pre_hi_q, pre_lo_q;
  logic              raw_pre_q, raw_rst_q;
  logic              wr_ok, is_lock, is_load, clr_pre, clr_rst;
  logic              unused_hi;

  assign unused_hi = ^wdata_i[BUS_W-1:HALF_W];
  assign is_lock   = (addr_i == ADDR_W'(OFF_LOCK));
  assign wr_ok     = wr_en_i && unlocked_q;
  assign is_load   = (addr_i == ADDR_W'(OFF_TO_LO))  || (addr_i == ADDR_W'(OFF_TO_HI)) ||
                     (addr_i == ADDR_W'(OFF_PRE_LO)) || (addr_i == ADDR_W'(OFF_PRE_HI));
  assign load_wr_o = wr_ok && is_load;
  assign clr_pre   = wr_ok && (addr_i == ADDR_W'(OFF_CLR)) && wdata_i[RAW_PRE_BIT];
  assign clr_rst   = wr_ok && (addr_i == ADDR_W'(OFF_CLR)) && wdata_i[RAW_RST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      ctrl_q     <= '0;
      mask_q     <= 1'b0;
      to_hi_q    <= '0;
      to_lo_q    <= '0;
      pre_hi_q   <= '0;
      pre_lo_q   <= '0;
      raw_pre_q  <= 1'b0;
      raw_rst_q  <= 1'b0;
    end else begin
      if (wr_en_i && is_lock) unlocked_q <= (wdata_i[15:0] == OPEN_KEY);
      if (wr_ok) begin
        if (addr_i == ADDR_W'(OFF_CTRL))   ctrl_q   <= wdata_i[3:0];
        if (addr_i == ADDR_W'(OFF_MASK))   mask_q   <= wdata_i[0];
        if (addr_i == ADDR_W'(OFF_TO_LO))  to_lo_q  <= wdata_i[HALF_W-1:0];
        if (addr_i == ADDR_W'(OFF_TO_HI))  to_hi_q  <= wdata_i[HALF_W-1:0];
        if (addr_i == ADDR_W'(OFF_PRE_LO)) pre_lo_q <= wdata_i[HALF_W-1:0];
        if (addr_i == ADDR_W'(OFF_PRE_HI)) pre_hi_q <= wdata_i[HALF_W-1:0];
      end
      // A new event wins over a clear in the same cycle.
      raw_pre_q <= pre_hit_i | (raw_pre_q & ~clr_pre);
      raw_rst_q <= expire_i  | (raw_rst_q & ~clr_rst);
    end
  end

  assign unlocked_o = unlocked_q;
  assign ctrl_o     = ctrl_q;
  assign mask_o     = mask_q;
  assign to_val_o   = {to_hi_q, to_lo_q};
  assign pre_val_o  = {pre_hi_q, pre_lo_q};
  assign raw_pre_o  = raw_pre_q;
  assign raw_rst_o  = raw_rst_q;

  assert_key_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && is_lock && wdata_i[15:0] == OPEN_KEY) |=> unlocked_q);
  assert_locked_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !unlocked_q && !is_lock) |=> $stable(ctrl_q) && $stable(to_val_o));
endmodule

// File: rtl/wdt_load_sync.sv
module wdt_load_sync #(
  parameter int LOAD_TICKS = 2,
  localparam int CW = $clog2(LOAD_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_wr_i,
  input  logic tick_i,
  output logic busy_o,
  output logic apply_o
);
  logic          busy_q;
  logic [CW-1:0] tcnt_q;

  assign apply_o = busy_q && tick_i && !load_wr_i && (tcnt_q == CW'(LOAD_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tcnt_q <= '0;
    end else if (load_wr_i) begin
      busy_q <= 1'b1;
      tcnt_q <= '0;
    end else if (apply_o) begin
      busy_q <= 1'b0;
      tcnt_q <= '0;
    end else if (busy_q && tick_i) begin
      tcnt_q <= tcnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;

  assert_load_sets_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr_i |=> busy_q);
  assert_apply_ends_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    apply_o |=> !busy_q);
endmodule

// File: rtl/wdt_downcounter.sv
module wdt_downcounter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             rst_en_i,
  input  logic             apply_i,
  input  logic [CNT_W-1:0] to_val_i,
  input  logic [CNT_W-1:0] pre_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             pre_hit_o,
  output logic             expire_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] count_q, pre_q;
  logic             rst_req_q;
  logic             step, fire;

  assign step      = tick_i && run_i && !apply_i;
  assign fire      = step && (count_q <= CNT_W'(1));
  assign pre_hit_o = step && !fire && ((count_q - CNT_W'(1)) == pre_q);
  assign expire_o  = fire && rst_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      pre_q     <= '0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= expire_o;
      if (apply_i) begin
        count_q <= to_val_i;
        pre_q   <= pre_val_i;
      end else if (fire) begin
        count_q <= to_val_i;
      end else if (step) begin
        count_q <= count_q - CNT_W'(1);
      end
    end
  end

  assign count_o   = count_q;
  assign rst_req_o = rst_req_q;

  assert_hold_without_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !apply_i) |=> $stable(count_q));
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> !rst_req_q);
endmodule

// File: rtl/keylock_watchdog.sv
module keylock_watchdog
  import wdt_pkg::*;
#(
  parameter int HALF_W     = 16,
  parameter int ADDR_W     = 6,
  parameter int BUS_W      = 32,
  parameter int LOAD_TICKS = 2,
  localparam int CNT_W     = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              wdt_irq,
  output logic              wdt_rst_req
);
  logic             unlocked, mask, raw_pre, raw_rst, load_wr, busy, apply;
  logic             pre_hit, expire;
  wdt_ctrl_t        ctrl;
  logic [CNT_W-1:0] to_val, pre_val, count;

  wdt_regfile #(.HALF_W(HALF_W), .ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .pre_hit_i(pre_hit), .expire_i(expire), .unlocked_o(unlocked), .ctrl_o(ctrl),
    .mask_o(mask), .to_val_o(to_val), .pre_val_o(pre_val), .raw_pre_o(raw_pre),
    .raw_rst_o(raw_rst), .load_wr_o(load_wr)
  );

  wdt_load_sync #(.LOAD_TICKS(LOAD_TICKS)) u_sync (
    .clk(clk), .rst_n(rst_n), .load_wr_i(load_wr), .tick_i(tick_en),
    .busy_o(busy), .apply_o(apply)
  );

  wdt_downcounter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .run_i(ctrl.cnt_en),
    .rst_en_i(ctrl.rst_en), .apply_i(apply), .to_val_i(to_val), .pre_val_i(pre_val),
    .count_o(count), .pre_hit_o(pre_hit), .expire_o(expire), .rst_req_o(wdt_rst_req)
  );

  assign wdt_irq = raw_pre && ctrl.int_en && !mask;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFF_TO_LO):  bus_rdata = BUS_W'(to_val[HALF_W-1:0]);
      ADDR_W'(OFF_TO_HI):  bus_rdata = BUS_W'(to_val[CNT_W-1:HALF_W]);
      ADDR_W'(OFF_PRE_LO): bus_rdata = BUS_W'(pre_val[HALF_W-1:0]);
      ADDR_W'(OFF_PRE_HI): bus_rdata = BUS_W'(pre_val[CNT_W-1:HALF_W]);
      ADDR_W'(OFF_CNT_LO): bus_rdata = BUS_W'(count[HALF_W-1:0]);
      ADDR_W'(OFF_CNT_HI): bus_rdata = BUS_W'(count[CNT_W-1:HALF_W]);
      ADDR_W'(OFF_CTRL):   bus_rdata = BUS_W'(ctrl);
      ADDR_W'(OFF_MASK):   bus_rdata = BUS_W'(mask);
      ADDR_W'(OFF_LOCK):   bus_rdata = BUS_W'(unlocked);
      ADDR_W'(OFF_RAW): begin
        bus_rdata[RAW_PRE_BIT]  = raw_pre;
        bus_rdata[RAW_RST_BIT]  = raw_rst;
        bus_rdata[RAW_BUSY_BIT] = busy;
      end
      default: bus_rdata = '0;
    endcase
  end

  assert_mask_blocks_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !wdt_irq);
endmodule

// File: tb/tb_keylock_watchdog.sv
module tb_keylock_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_irq, wdt_rst_req;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  keylock_watchdog dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_irq(wdt_irq), .wdt_rst_req(wdt_rst_req)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    check(bus_rdata, exp, tag);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      @(negedge clk);
    end
  endtask

  // {req, op, addr, data}: op 0 write, 1 read-and-compare, 2 tick count in data.
  localparam int NV = 29;
  localparam logic [43:0] VEC [NV] = '{
    {4'd1,  2'd1, 6'h20, 32'h0},     // R1 locked after reset
    {4'd10, 2'd1, 6'h08, 32'h0},     // R10 control resets to zero
    {4'd2,  2'd0, 6'h08, 32'hF},     // R2 write while locked
    {4'd2,  2'd1, 6'h08, 32'h0},     // R2 ignored
    {4'd1,  2'd0, 6'h20, 32'hE551},  // R1 key
    {4'd1,  2'd1, 6'h20, 32'h1},     // R1 unlocked
    {4'd3,  2'd0, 6'h04, 32'h0},     // R3 timeout high
    {4'd3,  2'd0, 6'h00, 32'hA},     // R3 timeout low
    {4'd3,  2'd0, 6'h30, 32'h0},     // R3 threshold high
    {4'd3,  2'd0, 6'h2C, 32'h4},     // R3 threshold low
    {4'd4,  2'd1, 6'h10, 32'h10},    // R4 busy
    {4'd3,  2'd1, 6'h00, 32'hA},     // R3 readback
    {4'd3,  2'd1, 6'h2C, 32'h4},     // R3 readback
    {4'd4,  2'd2, 6'h00, 32'd1},
    {4'd4,  2'd1, 6'h10, 32'h10},    // R4 still busy after one tick
    {4'd4,  2'd2, 6'h00, 32'd1},
    {4'd4,  2'd1, 6'h10, 32'h0},     // R4 busy cleared
    {4'd4,  2'd1, 6'h18, 32'hA},     // R4 count applied
    {4'd5,  2'd0, 6'h08, 32'h2},     // R5 count enable only
    {4'd5,  2'd2, 6'h00, 32'd3},
    {4'd5,  2'd1, 6'h18, 32'h7},     // R5 decremented
    {4'd6,  2'd2, 6'h00, 32'd3},
    {4'd6,  2'd1, 6'h10, 32'h1},     // R6 threshold hit
    {4'd8,  2'd0, 6'h0C, 32'h1},
    {4'd8,  2'd1, 6'h10, 32'h0},     // R8 cleared
    {4'd7,  2'd2, 6'h00, 32'd4},
    {4'd7,  2'd1, 6'h18, 32'hA},     // R7 reload without reset flag
    {4'd7,  2'd1, 6'h10, 32'h0},     // R7 no reset flag when disabled
    {4'd10, 2'd1, 6'h08, 32'h2}      // R10 readback
  };

  initial begin
    repeat (3) @(negedge clk);
    check({30'b0, wdt_irq, wdt_rst_req}, 32'h0, "R10 outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check({30'b0, wdt_irq, wdt_rst_req}, 32'h0, "R10 outputs after reset");

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      string       tag;
      v = VEC[i];
      tag = $sformatf("R%0d vector %0d", v[43:40], i);
      case (v[39:38])
        2'd0: wr(v[37:32], v[31:0]);
        2'd1: rd(v[37:32], v[31:0], tag);
        default: ticks(int'(v[31:0]));
      endcase
    end

    // Interrupt gating, R6 and R8: count is 10, threshold 4.
    wr(6'h08, 32'hB);
    ticks(6);
    check({31'b0, wdt_irq}, 32'h1, "R6 irq raised at threshold");
    wr(6'h14, 32'h1);
    check({31'b0, wdt_irq}, 32'h0, "R6 irq masked");
    wr(6'h14, 32'h0);
    check({31'b0, wdt_irq}, 32'h1, "R6 irq unmasked");
    wr(6'h0C, 32'h1);
    check({31'b0, wdt_irq}, 32'h0, "R8 irq cleared");

    // Expiry with reset enabled, R7.
    ticks(3);
    rd(6'h18, 32'h1, "R7 count at one");
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    check({31'b0, wdt_rst_req}, 32'h1, "R7 reset request raised");
    @(negedge clk);
    check({31'b0, wdt_rst_req}, 32'h0, "R7 reset request one cycle");
    rd(6'h10, 32'h8, "R7 reset flag");
    rd(6'h18, 32'hA, "R7 reload");
    wr(6'h0C, 32'h8);
    rd(6'h10, 32'h0, "R8 reset flag cleared");

    // Keep-alive, R9.
    ticks(3);
    wr(6'h00, 32'h14);
    ticks(1);
    rd(6'h18, 32'h6, "R9 old count runs during busy");
    ticks(1);
    rd(6'h18, 32'h14, "R9 restart from new timeout");

    // Locking, R1 and R2.
    wr(6'h20, 32'h0);
    rd(6'h20, 32'h0, "R1 relocked");
    wr(6'h08, 32'h0);
    rd(6'h08, 32'hB, "R2 control kept while locked");
    wr(6'h00, 32'h5);
    rd(6'h10, 32'h0, "R2 no busy from locked load");
    rd(6'h00, 32'h14, "R2 load kept while locked");
    wr(6'h20, 32'hE551);
    wr(6'h20, 32'h1234);
    rd(6'h20, 32'h0, "R1 wrong key locks");

    // 32-bit count split across halves, R5.
    wr(6'h20, 32'hE551);
    wr(6'h08, 32'h2);
    wr(6'h04, 32'h1);
    wr(6'h00, 32'h0);
    ticks(2);
    rd(6'h1C, 32'h1, "R5 count high half");
    rd(6'h18, 32'h0, "R5 count low half");
    ticks(1);
    rd(6'h1C, 32'h0, "R5 borrow into high half");
    rd(6'h18, 32'hFFFF, "R5 low after borrow");
    repeat (5) @(negedge clk);
    rd(6'h18, 32'hFFFF, "R5 hold without tick");
    wr(6'h08, 32'h0);
    ticks(2);
    rd(6'h18, 32'hFFFF, "R5 hold when disabled");

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule